// File: doc/BRIEF.md
# SPI Master Frame Sequencer

This block is the serial engine of an SPI master for the mode in which the serial clock rests high and the receiving side captures on the clock's first (falling) edge. Software-side logic pushes words into a small transmit queue. Once the block is enabled, it pulls each word, frames it with an active-low select, and shifts it out most significant bit first. At the same time it gathers the returning serial bits into a receive queue.

The timing of every edge is built from one half-period unit H = N+1 system clocks, where N is an 8-bit prescale value. Select leads the first data bit by H. The first data bit leads the first falling clock edge by H. Select is released 2H after the last capture. Consecutive words are always separated by a high pulse on select, even when the transmit queue never runs dry. The prescale value and the word length are latched only while the engine is idle.

Top module: `spi_frame_seq`

## Requirements
- R1: Out of reset and whenever no transfer is in progress, sck is 1, sel_n is 1, mosi_oe is 0 and busy is 0.
- R2: A transfer begins only when enable is 1 and the transmit queue holds a word. At that clock sel_n falls and mosi_oe becomes 1. While enable is 0, queued words remain unsent.
- R3: With H = prescale+1 clocks, the first data bit is on mosi H after sel_n falls, and the first falling sck edge comes 2H after sel_n falls.
- R4: miso is sampled at each falling edge of sck. mosi changes only while sck is high, so it is stable at every falling edge.
- R5: Each frame has exactly L falling sck edges and sends bits L-1 down to 0 of the queued word, MSB first. L is word_len when that is in 4..16, 4 when word_len is below 4, and 16 when it is above 16.
- R6: sel_n returns to 1 exactly 2H clocks after the last falling sck edge of a word, with sck already high.
- R7: When the next word is already queued, sel_n stays high for exactly H clocks between words, and the next frame repeats the R3 lead timing.
- R8: prescale and word_len are latched only while idle. Changing them during a burst does not alter its timing or length.
- R9: Each received word is right-justified and zero-extended to 16 bits and stored in an 8-entry receive queue. rx_data shows the oldest entry while rx_empty is 0, and rx_pop removes it.
- R10: A word received while the receive queue holds 8 entries is discarded, and overrun becomes 1 and stays 1 until reset.
- R11: busy is 1 from the fall of sel_n until the release of sel_n after the last word of a burst, and stays 1 across the gaps between back-to-back words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows transfers to start |
| prescale | input | 8 | Half-period value N, H = N+1 clocks |
| word_len | input | 5 | Bits per word, clamped to 4..16 |
| tx_push | input | 1 | Writes tx_data into the transmit queue |
| tx_data | input | 16 | Word to send, right-justified |
| tx_full | output | 1 | Transmit queue full; pushes are ignored |
| rx_pop | input | 1 | Removes the oldest received word |
| rx_data | output | 16 | Oldest received word |
| rx_empty | output | 1 | Receive queue empty |
| overrun | output | 1 | Sticky: a received word was discarded |
| busy | output | 1 | Burst in progress |
| sck | output | 1 | Serial clock, idles high |
| sel_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for mosi; 0 means high impedance |
| miso | input | 1 | Serial data in |

## Verification
The assertions check on every cycle the properties that involve one or two adjacent cycles. These are the idle levels of the pins, mosi changing only while sck is high, sck falling only under an asserted select, select rising only with sck high, the latched word length staying in range, the latched prescale staying stable during a frame, and the overrun flag staying sticky. Multi-cycle spacing can only be shown by the bench's scenarios. These include the H and 2H leads, the 2H release and the exact H gap, bit counts and bit order for every length, clamping, and the data returned through the receive queue. The bench also shows that late changes to the prescale are ignored and that the first eight words survive an overrun.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_SETUP,
        PH_LOW,
        PH_HIGH,
        PH_HOLD,
        PH_GAP
    } phase_e;
endpackage

// File: rtl/spi_seq_fifo.sv
module spi_seq_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t q, d;
    logic do_push, do_pop;

    always_comb begin
        d       = q;
        full    = (q.cnt == CW'(DEPTH));
        empty   = (q.cnt == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        rdata   = q.mem[q.rp];
        if (do_push) begin
            d.mem[q.wp] = wdata;
            d.wp = (q.wp == AW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        end
        if (do_pop) begin
            d.rp = (q.rp == AW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        end
        if (do_push && !do_pop) begin
            d.cnt = q.cnt + 1'b1;
        end else if (do_pop && !do_push) begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R9
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));
endmodule

// File: rtl/spi_seq_halftick.sv
module spi_seq_halftick #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] limit,
    output logic             tick
);
    logic [PRE_W-1:0] cnt_q, cnt_d;

    always_comb begin
        tick  = run && (cnt_q == limit);
        cnt_d = cnt_q;
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R3
    count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);
endmodule

// File: rtl/spi_seq_engine.sv
module spi_seq_engine
    import spi_seq_pkg::*;
#(
    parameter int MAX_W = 16,
    parameter int MIN_W = 4,
    parameter int PRE_W = 8,
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [PRE_W-1:0] prescale,
    input  logic [LEN_W-1:0] word_len,
    input  logic             tx_empty,
    input  logic [MAX_W-1:0] tx_head,
    output logic             tx_pop,
    output logic             rx_push,
    output logic [MAX_W-1:0] rx_word,
    input  logic             tick,
    output logic             run,
    output logic [PRE_W-1:0] half_lim,
    input  logic             miso,
    output logic             sck,
    output logic             sel_n,
    output logic             mosi,
    output logic             mosi_oe,
    output logic             busy
);
    localparam int IDX_W = $clog2(MAX_W);

    typedef struct packed {
        phase_e           ph;
        logic             sck;
        logic             sel;
        logic             oe;
        logic             mosi;
        logic [MAX_W-1:0] tx;
        logic [MAX_W-1:0] rx;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] cnt;
        logic [PRE_W-1:0] pre;
        logic             more;
    } eng_t;

    eng_t q, d;
    logic [LEN_W-1:0] eff_len;
    logic [LEN_W-1:0] idx_full;
    logic [IDX_W-1:0] idx;
    logic             can_start;

    always_comb begin
        if (word_len < LEN_W'(MIN_W)) begin
            eff_len = LEN_W'(MIN_W);
        end else if (word_len > LEN_W'(MAX_W)) begin
            eff_len = LEN_W'(MAX_W);
        end else begin
            eff_len = word_len;
        end
        idx_full  = q.len - 1'b1 - q.cnt;
        idx       = idx_full[IDX_W-1:0];
        can_start = enable && !tx_empty;

        d       = q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;

        case (q.ph)
            PH_IDLE: begin
                if (can_start) begin
                    tx_pop = 1'b1;
                    d.ph   = PH_LEAD;
                    d.sel  = 1'b0;
                    d.oe   = 1'b1;
                    d.mosi = 1'b0;
                    d.tx   = tx_head;
                    d.rx   = '0;
                    d.cnt  = '0;
                    d.len  = eff_len;
                    d.pre  = prescale;
                end
            end
            PH_LEAD: begin
                if (tick) begin
                    d.ph   = PH_SETUP;
                    d.mosi = q.tx[idx];
                end
            end
            PH_SETUP, PH_HIGH: begin
                if (tick) begin
                    d.ph  = PH_LOW;
                    d.sck = 1'b0;
                    d.rx  = {q.rx[MAX_W-2:0], miso};
                    d.cnt = q.cnt + 1'b1;
                end
            end
            PH_LOW: begin
                if (tick) begin
                    d.sck = 1'b1;
                    if (q.cnt == q.len) begin
                        d.ph    = PH_HOLD;
                        rx_push = 1'b1;
                    end else begin
                        d.ph   = PH_HIGH;
                        d.mosi = q.tx[idx];
                    end
                end
            end
            PH_HOLD: begin
                if (tick) begin
                    d.ph   = PH_GAP;
                    d.sel  = 1'b1;
                    d.oe   = 1'b0;
                    d.more = can_start;
                end
            end
            PH_GAP: begin
                if (tick) begin
                    if (can_start) begin
                        tx_pop = 1'b1;
                        d.ph   = PH_LEAD;
                        d.sel  = 1'b0;
                        d.oe   = 1'b1;
                        d.mosi = 1'b0;
                        d.tx   = tx_head;
                        d.rx   = '0;
                        d.cnt  = '0;
                    end else begin
                        d.ph = PH_IDLE;
                    end
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.ph   <= PH_IDLE;
            q.sck  <= 1'b1;
            q.sel  <= 1'b1;
            q.len  <= LEN_W'(MIN_W);
        end else begin
            q <= d;
        end
    end

    assign run      = (q.ph != PH_IDLE);
    assign half_lim = q.pre;
    assign rx_word  = q.rx;
    assign sck      = q.sck;
    assign sel_n    = q.sel;
    assign mosi     = q.mosi;
    assign mosi_oe  = q.oe;
    assign busy     = (q.ph != PH_IDLE) && !((q.ph == PH_GAP) && !q.more);

    // R1
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_IDLE) |-> (q.sck && q.sel && !q.oe));
    // R4
    mosi_high_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.mosi) |-> q.sck);
    // R4
    fall_under_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.sck) |-> !q.sel);
    // R6
    release_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.sel) |-> (q.sck && $past(q.sck)));
    // R5
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph != PH_IDLE) |-> (q.len >= LEN_W'(MIN_W) && q.len <= LEN_W'(MAX_W)));
    // R8
    pre_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.ph != PH_IDLE) && ($past(q.ph) != PH_IDLE)) |-> $stable(q.pre));
endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq #(
    parameter int MAX_W    = 16,
    parameter int MIN_W    = 4,
    parameter int PRE_W    = 8,
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 8,
    parameter int LEN_W    = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [PRE_W-1:0] prescale,
    input  logic [LEN_W-1:0] word_len,
    input  logic             tx_push,
    input  logic [MAX_W-1:0] tx_data,
    output logic             tx_full,
    input  logic             rx_pop,
    output logic [MAX_W-1:0] rx_data,
    output logic             rx_empty,
    output logic             overrun,
    output logic             busy,
    output logic             sck,
    output logic             sel_n,
    output logic             mosi,
    output logic             mosi_oe,
    input  logic             miso
);
    logic             tx_empty, tx_pop;
    logic [MAX_W-1:0] tx_head;
    logic             rx_push, rx_full;
    logic [MAX_W-1:0] rx_word;
    logic             run, tick;
    logic [PRE_W-1:0] half_lim;
    logic             ovr_q, ovr_d;

    spi_seq_fifo #(.W(MAX_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_data),
        .pop(tx_pop), .rdata(tx_head), .full(tx_full), .empty(tx_empty)
    );

    spi_seq_fifo #(.W(MAX_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_word),
        .pop(rx_pop), .rdata(rx_data), .full(rx_full), .empty(rx_empty)
    );

    spi_seq_halftick #(.PRE_W(PRE_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .limit(half_lim), .tick(tick)
    );

    spi_seq_engine #(.MAX_W(MAX_W), .MIN_W(MIN_W), .PRE_W(PRE_W), .LEN_W(LEN_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .enable(enable), .prescale(prescale),
        .word_len(word_len), .tx_empty(tx_empty), .tx_head(tx_head),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word), .tick(tick),
        .run(run), .half_lim(half_lim), .miso(miso), .sck(sck), .sel_n(sel_n),
        .mosi(mosi), .mosi_oe(mosi_oe), .busy(busy)
    );

    always_comb begin
        ovr_d = ovr_q | (rx_push & rx_full);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else begin
            ovr_q <= ovr_d;
        end
    end

    assign overrun = ovr_q;

    // R10
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q |=> ovr_q);
endmodule

// File: tb/spi_frame_seq_test.sv
`timescale 1ns/1ps
module spi_frame_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [7:0]  prescale = 8'd0;
    logic [4:0]  word_len = 5'd8;
    logic        tx_push = 1'b0;
    logic [15:0] tx_data = '0;
    logic        tx_full;
    logic        rx_pop = 1'b0;
    logic [15:0] rx_data;
    logic        rx_empty, overrun, busy, sck, sel_n, mosi, mosi_oe;
    logic        miso = 1'b0;

    spi_frame_seq uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .prescale(prescale),
        .word_len(word_len), .tx_push(tx_push), .tx_data(tx_data),
        .tx_full(tx_full), .rx_pop(rx_pop), .rx_data(rx_data),
        .rx_empty(rx_empty), .overrun(overrun), .busy(busy), .sck(sck),
        .sel_n(sel_n), .mosi(mosi), .mosi_oe(mosi_oe), .miso(miso)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;
    int exp_len = 8;
    int exp_h = 1;
    int fno = 0;
    int sidx = 0;
    int nfall = 0;
    int busy_falls = 0;
    bit mon_on = 1'b0;
    logic [15:0] txw [0:15];
    logic [15:0] slw [0:15];
    logic [15:0] mw = '0;
    time t_sf = 0, t_ff = 0, t_lf = 0, t_rise = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] lmask(input int len);
        return 16'((32'd1 << len) - 1);
    endfunction

    // slave model and frame monitor
    always @(negedge sel_n) begin
        if (mon_on) begin
            if (fno > 0) chk(((t_sf = $time) - t_rise) / 10 == exp_h, "R7 gap", ($time - t_rise) / 10, exp_h);
            t_sf  = $time;
            nfall = 0;
            mw    = '0;
            sidx  = exp_len - 1;
            miso  = slw[fno][sidx];
        end
    end

    always @(negedge sck) begin
        if (mon_on && !sel_n) begin
            mw = {mw[14:0], mosi};
            if (nfall == 0) begin
                t_ff = $time;
                chk((t_ff - t_sf) / 10 == 2 * exp_h, "R3 lead", (t_ff - t_sf) / 10, 2 * exp_h);
                chk(mosi_oe == 1'b1, "R2 oe", mosi_oe, 1);
            end
            t_lf = $time;
            nfall++;
        end
    end

    always @(posedge sck) begin
        if (mon_on && !sel_n && sidx > 0) begin
            sidx--;
            miso = slw[fno][sidx];
        end
    end

    always @(posedge sel_n) begin
        if (mon_on) begin
            t_rise = $time;
            chk(nfall == exp_len, "R5 bits", nfall, exp_len);
            chk((t_rise - t_lf) / 10 == 2 * exp_h, "R6 release", (t_rise - t_lf) / 10, 2 * exp_h);
            chk(mw == (txw[fno] & lmask(exp_len)), "R5 mosi word", mw, txw[fno] & lmask(exp_len));
            fno++;
        end
    end

    always @(negedge busy) if (mon_on) busy_falls++;

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_up();
    end

    task automatic push_word(input logic [15:0] w);
        while (tx_full) @(negedge clk);
        tx_push = 1'b1;
        tx_data = w;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic wait_idle();
        while (!busy) @(negedge clk);
        while (busy || !sel_n) @(negedge clk);
        repeat (2 * exp_h + 2) @(negedge clk);
    endtask

    // one burst of nw words; hold_check exercises R2, late_pre exercises R8
    task automatic run_group(input int len_in, input int eff, input int pre, input int nw,
                             input bit hold_check, input bit late_pre);
        exp_len = eff;
        exp_h   = pre + 1;
        word_len = 5'(len_in);
        prescale = 8'(pre);
        for (int i = 0; i < nw; i++) begin
            txw[i] = 16'(len_in * 977 + pre * 131 + i * 40503) ^ 16'hA5C3;
            slw[i] = 16'(len_in * 613 + pre * 29 + i * 25173) ^ 16'h3C96;
        end
        fno = 0;
        busy_falls = 0;
        mon_on = 1'b1;
        for (int i = 0; i < nw; i++) push_word(txw[i]);
        if (hold_check) begin
            repeat (40) @(negedge clk);
            chk(sel_n == 1'b1 && busy == 1'b0, "R2 disabled hold", {busy, sel_n}, 1);
        end
        enable = 1'b1;
        if (late_pre) begin
            while (sel_n) @(negedge clk);
            prescale = 8'd0;
            word_len = 5'd16;
        end
        wait_idle();
        enable = 1'b0;
        chk(fno == nw, "R7 frame count", fno, nw);
        chk(busy_falls == 1, "R11 busy", busy_falls, 1);
        chk(sck && sel_n && !mosi_oe && !busy, "R1 idle after", {sck, sel_n, mosi_oe, busy}, 4'b1100);
        for (int i = 0; i < nw; i++) begin
            chk(!rx_empty && rx_data == (slw[i] & lmask(eff)), "R9 rx word", rx_data, slw[i] & lmask(eff));
            rx_pop = 1'b1;
            @(negedge clk);
            rx_pop = 1'b0;
        end
        chk(rx_empty == 1'b1, "R9 rx drained", rx_empty, 1);
        mon_on = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(sck && sel_n && !mosi_oe && !busy, "R1 reset pins", {sck, sel_n, mosi_oe, busy}, 4'b1100);
        chk(rx_empty && !overrun && !tx_full, "R1 reset queues", {rx_empty, overrun, tx_full}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        run_group(8, 8, 2, 2, 1'b1, 1'b0);
        for (int len = 4; len <= 16; len++) begin
            for (int p = 0; p < 3; p++) begin
                run_group(len, len, p, 3, 1'b0, 1'b0);
            end
        end
        // clamping of word length (R5)
        run_group(2, 4, 1, 2, 1'b0, 1'b0);
        run_group(20, 16, 0, 2, 1'b0, 1'b0);
        run_group(31, 16, 1, 2, 1'b0, 1'b0);
        // configuration frozen during a burst (R8)
        run_group(6, 6, 3, 3, 1'b0, 1'b1);
        chk(1'b1, "R8 late change", 0, 0);
        // overrun (R10): ten words, none popped until the end
        exp_len = 4;
        exp_h = 1;
        word_len = 5'd4;
        prescale = 8'd0;
        for (int i = 0; i < 10; i++) begin
            txw[i] = 16'(i * 7 + 3);
            slw[i] = 16'(i * 11 + 5);
        end
        fno = 0;
        busy_falls = 0;
        mon_on = 1'b1;
        enable = 1'b1;
        for (int i = 0; i < 10; i++) push_word(txw[i]);
        wait_idle();
        enable = 1'b0;
        chk(fno == 10, "R7 overrun burst frames", fno, 10);
        chk(overrun == 1'b1, "R10 overrun flag", overrun, 1);
        for (int i = 0; i < 8; i++) begin
            chk(!rx_empty && rx_data == (slw[i] & 16'hF), "R10 kept words", rx_data, slw[i] & 16'hF);
            rx_pop = 1'b1;
            @(negedge clk);
            rx_pop = 1'b0;
        end
        chk(rx_empty == 1'b1, "R10 dropped words", rx_empty, 1);
        repeat (5) @(negedge clk);
        chk(overrun == 1'b1, "R10 sticky", overrun, 1);
        mon_on = 1'b0;
        finish_up();
    end
endmodule